// File: doc/BRIEF.md
# Transmit Checksum Insertion Engine

This block sits in an Ethernet transmit path and fills in a 16-bit ones'-complement checksum for each outgoing frame. Bytes enter on a valid/ready stream with an end-of-frame marker. A set of per-frame control inputs, sampled together with the first byte, gives three values: the byte offset where summing begins, the byte offset where the result goes, and a 16-bit seed. Software puts any pseudo-header contribution into the seed. The control inputs also carry a per-frame enable.

The result is usually written at an offset that comes before the end of the summed range, so the block stores the whole frame in an internal buffer. It forms the sum while the frame is being stored. It then replays the frame on an output valid/ready stream and overwrites two bytes with the inverted sum. A separate input reports whether automatic FCS generation is active further down the path. When it is not, the block never modifies a frame, because a frame check sequence built by software over that frame would no longer match.

Top module: `txck_inserter`

## Requirements
- R1: The inserted value is the bitwise inverse of the ones'-complement sum (end-around carry) of the seed and the big-endian 16-bit words formed from the frame bytes, counted from the start offset to the final stored byte. The original bytes at the insert offset are part of this sum.
- R2: When the summed range has an odd number of bytes, its final byte is treated as the high byte of a word whose low byte is 0x00. This includes a one-byte frame.
- R3: Bytes before the start offset are not summed. If the start offset is at or beyond the frame length, the inserted value is the inverse of the seed.
- R4: When checksumming is active, output byte `insert` carries bits 15:8 of the result and byte `insert+1` carries bits 7:0. Every other byte leaves unchanged.
- R5: When the frame's enable input (`ck_en`, sampled with the first byte) is 0, the frame leaves byte for byte unchanged.
- R6: When `fcs_auto_on` (sampled with the first byte) is 0, the frame leaves byte for byte unchanged, whatever `ck_en` holds.
- R7: `in_ready` is low from the cycle after the last input byte is accepted until the last output byte has been handshaken. `out_valid` is never high in a cycle where an input byte is accepted.
- R8: While `out_valid` is high and `out_ready` is low, `out_data` and `out_last` hold. `out_last` is high only on the final byte, and no byte is lost or repeated.
- R9: If the insert offset is the final byte of the frame, only the high result byte is written. The low byte falls outside the frame and is dropped.
- R10: Bytes beyond `MAX_BYTES` are neither stored nor summed. The emitted frame is cut to `MAX_BYTES` bytes, with `out_last` on the final stored byte.
- R11: After reset, `in_ready` is 1 and `out_valid` is 0, and a frame that was partly received is discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Input byte valid |
| in_ready | output | 1 | Block can accept an input byte |
| in_data | input | 8 | Input byte |
| in_last | input | 1 | Marks the final input byte of a frame |
| ck_en | input | 1 | Per-frame checksum enable, sampled with first byte |
| ck_start | input | LEN_W | Offset of first summed byte, sampled with first byte |
| ck_put | input | LEN_W | Offset of the high result byte, sampled with first byte |
| ck_seed | input | 16 | Initial sum value, sampled with first byte |
| fcs_auto_on | input | 1 | Downstream FCS generation is active, sampled with first byte |
| out_valid | output | 1 | Output byte valid |
| out_ready | input | 1 | Sink accepts output byte |
| out_data | output | 8 | Output byte |
| out_last | output | 1 | Marks the final output byte |

## Verification
The bench covers several cases that an incorrect design would get wrong. An all-ones seed with 0xFF data forces the end-around carry; a design that drops the carry shifts the result by one. Odd-length ranges and one-byte frames check zero padding in the low byte; a design that pads the high byte or leaves a pending byte out of the sum produces a different value. A start offset equal to the frame length must leave the inverse of the seed. An insert offset on the final byte must not run past the end of the frame. An over-long frame must be cut while a pending odd byte is still added to the sum. Stalls on the output side, applied in different patterns, would show up as duplicated, lost or changing bytes if the buffer read did not stall together with the output register.

// File: rtl/txck_pkg.sv
package txck_pkg;

  typedef enum logic {
    ST_FILL  = 1'b0,
    ST_DRAIN = 1'b1
  } txck_state_e;

  // ones'-complement addition with end-around carry
  function automatic logic [15:0] oc_add(input logic [15:0] a, input logic [15:0] b);
    logic [16:0] t;
    t = {1'b0, a} + {1'b0, b};
    return t[15:0] + {15'd0, t[16]};
  endfunction

endpackage

// File: rtl/txck_frame_ram.sv
module txck_frame_ram #(
  parameter int DEPTH = 2048,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [7:0]    wdata,
  input  logic          re,
  input  logic [AW-1:0] raddr,
  output logic [7:0]    rdata
);

  logic [7:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    if (re) rdata <= mem[raddr];
  end

endmodule

// File: rtl/txck_sum_acc.sv
module txck_sum_acc
  import txck_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic        take,     // a byte is accepted this cycle
  input  logic        first,    // it is the first byte of the frame
  input  logic        use_byte, // it is stored and inside the summed range
  input  logic        last,     // it is the final input byte
  input  logic [7:0]  data,
  input  logic [15:0] seed,
  output logic [15:0] result
);

  logic [15:0] sum_q, sum_d, base_sum;
  logic [7:0]  hi_q, hi_d;
  logic        ph_q, ph_d, base_ph;

  always_comb begin
    base_sum = first ? seed : sum_q;
    base_ph  = first ? 1'b0 : ph_q;
    sum_d    = base_sum;
    ph_d     = base_ph;
    hi_d     = hi_q;
    if (use_byte) begin
      if (!base_ph) begin
        if (last) begin
          sum_d = oc_add(base_sum, {data, 8'h00});
        end else begin
          hi_d = data;
          ph_d = 1'b1;
        end
      end else begin
        sum_d = oc_add(base_sum, {hi_q, data});
        ph_d  = 1'b0;
      end
    end else if (last && base_ph) begin
      // frame cut short: flush the pending high byte
      sum_d = oc_add(base_sum, {hi_q, 8'h00});
      ph_d  = 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sum_q <= '0;
      hi_q  <= '0;
      ph_q  <= 1'b0;
    end else if (take) begin
      sum_q <= sum_d;
      hi_q  <= hi_d;
      ph_q  <= ph_d;
    end
  end

  assign result = ~sum_q;

  // R3: a first byte outside the summed range leaves only the seed
  a_r3_seed_only: assert property (@(posedge clk) disable iff (rst)
    take && first && !use_byte |=> sum_q == $past(seed));

  // R2: no half word is left pending once the frame has ended
  a_r2_pad_flush: assert property (@(posedge clk) disable iff (rst)
    take && last |=> !ph_q);

endmodule

// File: rtl/txck_out_pipe.sv
module txck_out_pipe #(
  parameter int LW = 12,
  parameter int AW = 11
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          go,
  input  logic [LW-1:0] len,
  input  logic [15:0]   csum,
  input  logic          ins_en,
  input  logic [LW-1:0] ins_ofs,
  output logic          ram_re,
  output logic [AW-1:0] ram_addr,
  input  logic [7:0]    ram_q,
  output logic          out_valid,
  input  logic          out_ready,
  output logic [7:0]    out_data,
  output logic          out_last,
  output logic          done
);

  logic          busy_q;
  logic [LW-1:0] ptr_q;
  logic          p1_v, p1_last;
  logic [LW-1:0] p1_idx;
  logic          load, issue;
  logic [LW:0]   ins_lo;
  logic [7:0]    sel;

  assign load     = !out_valid || out_ready;
  assign issue    = busy_q && (ptr_q < len);
  assign ram_re   = load;
  assign ram_addr = ptr_q[AW-1:0];
  assign ins_lo   = {1'b0, ins_ofs} + 1'b1;
  assign done     = out_valid && out_ready && out_last;

  always_comb begin
    sel = ram_q;
    if (ins_en && p1_idx == ins_ofs)                 sel = csum[15:8];
    else if (ins_en && {1'b0, p1_idx} == ins_lo)     sel = csum[7:0];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_q    <= 1'b0;
      ptr_q     <= '0;
      p1_v      <= 1'b0;
      p1_last   <= 1'b0;
      p1_idx    <= '0;
      out_valid <= 1'b0;
      out_data  <= '0;
      out_last  <= 1'b0;
    end else begin
      if (go) begin
        busy_q <= 1'b1;
        ptr_q  <= '0;
        p1_v   <= 1'b0;
      end else if (load) begin
        p1_v      <= issue;
        p1_idx    <= ptr_q;
        p1_last   <= (ptr_q == len - 1'b1);
        if (issue) ptr_q <= ptr_q + 1'b1;
        out_valid <= p1_v;
        out_data  <= sel;
        out_last  <= p1_v && p1_last;
      end
      if (done) busy_q <= 1'b0;
    end
  end

  // R8: a stalled byte holds its value and marker
  a_r8_hold_stall: assert property (@(posedge clk) disable iff (rst)
    out_valid && !out_ready |=> out_valid && $stable(out_data) && $stable(out_last));

  // R8: nothing follows the final byte of a frame
  a_r8_last_gap: assert property (@(posedge clk) disable iff (rst)
    done |=> !out_valid);

endmodule

// File: rtl/txck_inserter.sv
module txck_inserter
  import txck_pkg::*;
#(
  parameter int MAX_BYTES = 2048,
  localparam int LEN_W = $clog2(MAX_BYTES + 1),
  localparam int ADDR_W = $clog2(MAX_BYTES)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [7:0]       in_data,
  input  logic             in_last,
  input  logic             ck_en,
  input  logic [LEN_W-1:0] ck_start,
  input  logic [LEN_W-1:0] ck_put,
  input  logic [15:0]      ck_seed,
  input  logic             fcs_auto_on,
  output logic             out_valid,
  input  logic             out_ready,
  output logic [7:0]       out_data,
  output logic             out_last
);

  localparam logic [LEN_W-1:0] CAP = LEN_W'(MAX_BYTES);

  txck_state_e      st_q;
  logic             first_q;
  logic [LEN_W-1:0] wr_cnt, len_q, start_q, put_q;
  logic             en_q, go_q;
  logic             take, first, stored, use_byte, done;
  logic [LEN_W-1:0] cur_start;
  logic             ram_re;
  logic [ADDR_W-1:0] ram_raddr;
  logic [7:0]       ram_q;
  logic [15:0]      csum;

  assign in_ready  = (st_q == ST_FILL);
  assign take      = in_valid && in_ready;
  assign first     = take && first_q;
  assign cur_start = first_q ? ck_start : start_q;
  assign stored    = wr_cnt < CAP;
  assign use_byte  = take && stored && (wr_cnt >= cur_start);

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q    <= ST_FILL;
      first_q <= 1'b1;
      wr_cnt  <= '0;
      len_q   <= '0;
      start_q <= '0;
      put_q   <= '0;
      en_q    <= 1'b0;
      go_q    <= 1'b0;
    end else begin
      go_q <= 1'b0;
      if (take) begin
        if (first_q) begin
          start_q <= ck_start;
          put_q   <= ck_put;
          en_q    <= ck_en && fcs_auto_on;
          first_q <= 1'b0;
        end
        if (stored) wr_cnt <= wr_cnt + 1'b1;
        if (in_last) begin
          len_q   <= stored ? wr_cnt + 1'b1 : wr_cnt;
          wr_cnt  <= '0;
          first_q <= 1'b1;
          st_q    <= ST_DRAIN;
          go_q    <= 1'b1;
        end
      end
      if (done) st_q <= ST_FILL;
    end
  end

  txck_frame_ram #(.DEPTH(MAX_BYTES)) u_ram (
    .clk   (clk),
    .we    (take && stored),
    .waddr (wr_cnt[ADDR_W-1:0]),
    .wdata (in_data),
    .re    (ram_re),
    .raddr (ram_raddr),
    .rdata (ram_q)
  );

  txck_sum_acc u_acc (
    .clk      (clk),
    .rst      (rst),
    .take     (take),
    .first    (first),
    .use_byte (use_byte),
    .last     (in_last),
    .data     (in_data),
    .seed     (ck_seed),
    .result   (csum)
  );

  txck_out_pipe #(.LW(LEN_W), .AW(ADDR_W)) u_out (
    .clk       (clk),
    .rst       (rst),
    .go        (go_q),
    .len       (len_q),
    .csum      (csum),
    .ins_en    (en_q),
    .ins_ofs   (put_q),
    .ram_re    (ram_re),
    .ram_addr  (ram_raddr),
    .ram_q     (ram_q),
    .out_valid (out_valid),
    .out_ready (out_ready),
    .out_data  (out_data),
    .out_last  (out_last),
    .done      (done)
  );

  // R7: input and output phases never overlap
  a_r7_no_overlap: assert property (@(posedge clk) disable iff (rst)
    take |-> !out_valid);

  // R10: a replayed frame never exceeds the buffer
  a_r10_len_cap: assert property (@(posedge clk) disable iff (rst)
    go_q |-> (len_q <= CAP) && (len_q != '0));

endmodule

// File: tb/txck_inserter_tb.sv
module txck_inserter_tb;

  localparam int MAXB = 64;
  localparam int LW = $clog2(MAXB + 1);
  localparam int NV = 10;

  localparam int V_LEN  [NV] = '{20, 21, 60, 10, 10, 8, 9, 1, 70, 12};
  localparam int V_ST   [NV] = '{0, 14, 14, 3, 3, 8, 0, 0, 1, 2};
  localparam int V_INS  [NV] = '{4, 16, 30, 0, 0, 2, 8, 0, 10, 0};
  localparam int V_SEED [NV] = '{'h0000, 'h1234, 'hFFFF, 'hABCD, 'hABCD, 'h5A5A, 'h0001, 'h0000, 'h0000, 'hFFFF};
  localparam int V_EN   [NV] = '{1, 1, 1, 0, 1, 1, 1, 1, 1, 1};
  localparam int V_FCS  [NV] = '{1, 1, 1, 1, 0, 1, 1, 1, 1, 1};
  localparam int V_STL  [NV] = '{0, 1, 2, 0, 1, 0, 2, 0, 1, 2};
  localparam int V_KIND [NV] = '{0, 0, 0, 0, 0, 0, 0, 0, 0, 1};
  localparam string V_TAG [NV] = '{"R1", "R2", "R1", "R5", "R6", "R3", "R9", "R2", "R10", "R1"};

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic in_valid = 1'b0, in_last = 1'b0, ck_en = 1'b0, fcs_auto_on = 1'b1, out_ready = 1'b0;
  logic [7:0] in_data = '0;
  logic [LW-1:0] ck_start = '0, ck_put = '0;
  logic [15:0] ck_seed = '0;
  logic in_ready, out_valid, out_last;
  logic [7:0] out_data;

  int checks = 0;
  int fails = 0;
  int cycles = 0;

  always #10 clk = ~clk;

  txck_inserter #(.MAX_BYTES(MAXB)) u_dut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
    .in_data(in_data), .in_last(in_last), .ck_en(ck_en), .ck_start(ck_start),
    .ck_put(ck_put), .ck_seed(ck_seed), .fcs_auto_on(fcs_auto_on),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data), .out_last(out_last)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", cycles, 100000);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  function automatic int gen_byte(int kind, int v, int i);
    if (kind == 1) return 'hFF;
    return (v * 37 + i * 13 + 5) & 'hFF;
  endfunction

  function automatic bit stall_now(int pat, int c);
    if (pat == 1) return (c % 3) == 0;
    if (pat == 2) return (c % 2) == 1;
    return 1'b0;
  endfunction

  task automatic run_frame(input int v);
    int len, lim, st, ins, en, fcs, pat, kind;
    int din [80];
    int dexp [80];
    longint acc;
    int csum, cnt, cyc, prev_d;
    bit prev_stall, got_last;
    string tag;
    len = V_LEN[v]; st = V_ST[v]; ins = V_INS[v]; en = V_EN[v];
    fcs = V_FCS[v]; pat = V_STL[v]; kind = V_KIND[v]; tag = V_TAG[v];
    lim = (len < MAXB) ? len : MAXB;
    for (int i = 0; i < len; i++) din[i] = gen_byte(kind, v, i);
    acc = V_SEED[v];
    for (int i = st; i < lim; i += 2) begin
      acc += longint'(din[i]) * 256 + ((i + 1 < lim) ? din[i + 1] : 0);
    end
    while ((acc >> 16) != 0) acc = (acc & 'hFFFF) + (acc >> 16);
    csum = int'(~acc) & 'hFFFF;
    for (int i = 0; i < lim; i++) dexp[i] = din[i];
    if (en == 1 && fcs == 1) begin
      if (ins < lim) dexp[ins] = (csum >> 8) & 'hFF;
      if (ins + 1 < lim) dexp[ins + 1] = csum & 'hFF;
    end
    // input phase
    for (int i = 0; i < len; i++) begin
      @(negedge clk);
      chk(in_ready == 1'b1 && out_valid == 1'b0, "R7 accept-phase", int'(in_ready), 1);
      in_valid = 1'b1;
      in_data  = 8'(din[i]);
      in_last  = (i == len - 1);
      ck_en    = (i == 0) ? 1'(en) : 1'b0;
      fcs_auto_on = (i == 0) ? 1'(fcs) : 1'b1;
      ck_start = (i == 0) ? LW'(st) : '0;
      ck_put   = (i == 0) ? LW'(ins) : '0;
      ck_seed  = (i == 0) ? 16'(V_SEED[v]) : 16'h0;
    end
    @(negedge clk);
    in_valid = 1'b0; in_last = 1'b0;
    chk(in_ready == 1'b0, "R7 busy-after-last", int'(in_ready), 0);
    // output phase
    cnt = 0; cyc = 0; prev_stall = 0; prev_d = 0; got_last = 0;
    while (!got_last && cyc < 2000) begin
      if (cyc > 0) @(negedge clk);
      if (prev_stall) chk(out_valid == 1'b1 && int'(out_data) == prev_d, "R8 hold", int'(out_data), prev_d);
      out_ready = !stall_now(pat, cyc);
      if (out_valid) begin
        if (out_ready) begin
          if (cnt < lim) begin
            if (en == 1 && fcs == 1 && (cnt == ins || cnt == ins + 1))
              chk(int'(out_data) == dexp[cnt], {tag, " R4 insert byte"}, int'(out_data), dexp[cnt]);
            else
              chk(int'(out_data) == dexp[cnt], {tag, " data byte"}, int'(out_data), dexp[cnt]);
          end
          chk(out_last == (cnt == lim - 1), "R8 last marker", int'(out_last), int'(cnt == lim - 1));
          if (out_last) got_last = 1;
          cnt++;
          prev_stall = 0;
        end else begin
          prev_stall = 1;
          prev_d = int'(out_data);
        end
      end else begin
        prev_stall = 0;
      end
      cyc++;
    end
    chk(cnt == lim, {tag, " R10 byte count"}, cnt, lim);
    @(negedge clk);
    out_ready = 1'b0;
    chk(out_valid == 1'b0 && in_ready == 1'b1, "R7 ready after drain", int'(in_ready), 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(in_ready == 1'b1 && out_valid == 1'b0, "R11 reset state", int'(out_valid), 0);
    rst = 1'b0;
    @(negedge clk);
    chk(in_ready == 1'b1 && out_valid == 1'b0, "R11 idle after reset", int'(in_ready), 1);

    for (int v = 0; v < NV; v++) run_frame(v);

    // R11: reset in the middle of a frame discards it
    for (int i = 0; i < 5; i++) begin
      @(negedge clk);
      in_valid = 1'b1; in_data = 8'(i + 1); in_last = 1'b0;
      ck_en = 1'b1; ck_start = '0; ck_put = '0; ck_seed = 16'h0;
    end
    @(negedge clk);
    in_valid = 1'b0;
    rst = 1'b1;
    repeat (2) @(negedge clk);
    chk(in_ready == 1'b1 && out_valid == 1'b0, "R11 mid-frame reset", int'(out_valid), 0);
    rst = 1'b0;
    run_frame(0);
    run_frame(8);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule